// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block accepts one decoded vectorised load and turns it into a stream of element memory requests, one request per accepted handshake. Every request carries the byte address of the element, the element's position in the vector and the destination register that the returned data will go to. Three addressing styles are chosen by the two top instruction bits:

- **Unit-element stride**: elements sit one element size apart.
- **Scaled stride**: the element-size step is multiplied by a register value.
- **Indexed**: a register value per element gives the offset directly.

The source register values that a register file would supply are presented on wide input buses. Each bus holds one slot per element. Slot `i` holds the value of register `r+i`, and slot 0 holds register `r` itself.

A predicate mask and a vector length decide which elements are live. Elements whose mask bit is clear are skipped, so no idle cycle is spent on them. When the destination is a scalar register, the sequence stops after the first issued element. A scalar destination combined with predicate zeroing raises an exception pulse and issues nothing. At the end of every instruction the block emits a one-cycle completion pulse. It refuses a new instruction until the current one has finished.

Top module: `vlag_addr_gen`

## Requirements
- R1: With insn[31]=0 and insn[30]=0, element `i` goes to rs1 + i*size + imm, where imm is the sign-extended 10-bit value {insn[29:24], insn[23:20]}.
- R2: With insn[31]=0 and insn[30]=1, element `i` goes to rs1 + i*size*rs2 + imm, where imm is the sign-extended 4-bit value insn[23:20].
- R3: With insn[31]=1, element `i` goes to rs1 + rs2 + imm, where imm is the sign-extended 5-bit value {insn[30], insn[23:20]}.
- R4: The element size in bytes is 1, 2, 4 or 8 for insn[13:12] = 0, 1, 2 or 3.
- R5: A register flagged as vector supplies slot `i` of its bus for element `i`. A register flagged as scalar supplies slot 0 for every element.
- R6: Only elements with their predicate bit set and an index below the vector length are issued. They are issued in ascending index order, one per handshake, and req_elem carries the index.
- R7: For a vector destination, req_dest = (insn[11:7] + i) mod 32. For a scalar destination, req_dest = insn[11:7] and the sequence ends after the first issued element.
- R8: A scalar destination with pred_zero set produces exc and done together in the cycle after acceptance, with no request. pred_zero has no effect for a vector destination.
- R9: A vector length of zero, or no live element, produces done in the cycle after acceptance with no request.
- R10: While req_valid is high and req_ready is low, the request and its fields stay unchanged. done is high for exactly the one cycle after the final handshake.
- R11: start_ready is low from acceptance until done. A start_valid presented in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | A load instruction is offered |
| start_ready | output | 1 | Block is idle and takes the offered instruction |
| insn | input | 32 | Load instruction word |
| rs1_vec | input | 1 | Base register is a vector |
| rs2_vec | input | 1 | Stride/index register is a vector |
| rd_vec | input | 1 | Destination register is a vector |
| pred_zero | input | 1 | Zeroing enabled on the predicate |
| pred_mask | input | VLMAX | Predicate mask, bit i for element i |
| vl | input | LW | Vector length |
| rs1_vals | input | VLMAX*AW | Base register values, slot i = register rs1+i |
| rs2_vals | input | VLMAX*AW | Stride/index register values, slot i = register rs2+i |
| req_valid | output | 1 | Element request present |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | AW | Element byte address |
| req_elem | output | IW | Element index |
| req_dest | output | 5 | Destination register index |
| done | output | 1 | One-cycle end-of-instruction pulse |
| exc | output | 1 | One-cycle exception pulse |

## Verification
The bench builds the block with VLMAX=8 and AW=32. Eight element slots are enough to place predicate holes at both ends, between live elements, and above a shortened vector length. They also let a scalar destination stop partway along the vector. The 32-bit address width makes negative immediates wrap visibly.

The bench drives three req_ready patterns (always, alternate, one in three), so back-pressure holds a request at every position. Each of the four element sizes also appears at least once.

// File: rtl/vlag_pkg.sv
package vlag_pkg;

    typedef enum logic [1:0] {
        AM_UNIT  = 2'd0,
        AM_SCALE = 2'd1,
        AM_INDEX = 2'd2
    } amode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/vlag_decode.sv
module vlag_decode #(
    parameter int AW = 32
) (
    input  logic [31:0]          insn,
    output vlag_pkg::amode_e     mode,
    output logic [1:0]           size_log2,
    output logic [AW-1:0]        imm,
    output logic [4:0]           rd
);
    always_comb begin
        size_log2 = insn[13:12];
        rd        = insn[11:7];
        if (insn[31]) begin
            mode = vlag_pkg::AM_INDEX;
            imm  = {{(AW-5){insn[30]}}, insn[30], insn[23:20]};
        end else if (insn[30]) begin
            mode = vlag_pkg::AM_SCALE;
            imm  = {{(AW-4){insn[23]}}, insn[23:20]};
        end else begin
            mode = vlag_pkg::AM_UNIT;
            imm  = {{(AW-10){insn[29]}}, insn[29:24], insn[23:20]};
        end
    end
endmodule

// File: rtl/vlag_find.sv
module vlag_find #(
    parameter int VLMAX = 8,
    parameter int IW    = $clog2(VLMAX),
    parameter int LW    = $clog2(VLMAX + 1)
) (
    input  logic [VLMAX-1:0] mask,
    input  logic [LW-1:0]    vlen,
    input  logic [IW-1:0]    from,
    input  logic             incl,
    output logic             found,
    output logic [IW-1:0]    idx
);
    logic [VLMAX-1:0] live;

    generate
        for (genvar g = 0; g < VLMAX; g++) begin : g_live
            assign live[g] = mask[g] && (LW'(g) < vlen) &&
                             ((IW'(g) > from) || (incl && (IW'(g) == from)));
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = VLMAX - 1; j >= 0; j--) begin
            if (live[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/vlag_addr.sv
module vlag_addr #(
    parameter int VLMAX = 8,
    parameter int AW    = 32,
    parameter int IW    = $clog2(VLMAX)
) (
    input  vlag_pkg::amode_e       mode,
    input  logic [1:0]             size_log2,
    input  logic [AW-1:0]          imm,
    input  logic                   rs1_vec,
    input  logic                   rs2_vec,
    input  logic [VLMAX*AW-1:0]    rs1_vals,
    input  logic [VLMAX*AW-1:0]    rs2_vals,
    input  logic [IW-1:0]          elem,
    output logic [AW-1:0]          addr
);
    logic [AW-1:0] base_v;
    logic [AW-1:0] sec_v;
    logic [AW-1:0] elem_x;
    logic [AW-1:0] offs;

    always_comb begin
        elem_x = AW'(elem);
        base_v = rs1_vec ? rs1_vals[int'(elem)*AW +: AW] : rs1_vals[AW-1:0];
        sec_v  = rs2_vec ? rs2_vals[int'(elem)*AW +: AW] : rs2_vals[AW-1:0];
        case (mode)
            vlag_pkg::AM_INDEX: offs = sec_v;
            vlag_pkg::AM_SCALE: offs = (elem_x * sec_v) << size_log2;
            default:            offs = elem_x << size_log2;
        endcase
        addr = base_v + offs + imm;
    end
endmodule

// File: rtl/vlag_addr_gen.sv
module vlag_addr_gen #(
    parameter int VLMAX = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(VLMAX),
    localparam int LW   = $clog2(VLMAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_valid,
    output logic                   start_ready,
    input  logic [31:0]            insn,
    input  logic                   rs1_vec,
    input  logic                   rs2_vec,
    input  logic                   rd_vec,
    input  logic                   pred_zero,
    input  logic [VLMAX-1:0]       pred_mask,
    input  logic [LW-1:0]          vl,
    input  logic [VLMAX*AW-1:0]    rs1_vals,
    input  logic [VLMAX*AW-1:0]    rs2_vals,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [AW-1:0]          req_addr,
    output logic [IW-1:0]          req_elem,
    output logic [4:0]             req_dest,
    output logic                   done,
    output logic                   exc
);
    typedef struct packed {
        vlag_pkg::state_e          st;
        logic [IW-1:0]             elem;
        logic [VLMAX-1:0]          mask;
        logic [LW-1:0]             vlen;
        logic [31:0]               insn;
        logic                      v1;
        logic                      v2;
        logic                      vd;
        logic [VLMAX*AW-1:0]       r1;
        logic [VLMAX*AW-1:0]       r2;
        logic                      done;
        logic                      exc;
    } regs_t;

    regs_t s_d, s_q;

    logic              first_found;
    logic [IW-1:0]     first_idx;
    logic              next_found;
    logic [IW-1:0]     next_idx;
    vlag_pkg::amode_e  mode;
    logic [1:0]        size_log2;
    logic [AW-1:0]     imm;
    logic [4:0]        rd;

    vlag_find #(.VLMAX(VLMAX), .IW(IW), .LW(LW)) u_first (
        .mask  (pred_mask),
        .vlen  (vl),
        .from  ('0),
        .incl  (1'b1),
        .found (first_found),
        .idx   (first_idx)
    );

    vlag_find #(.VLMAX(VLMAX), .IW(IW), .LW(LW)) u_next (
        .mask  (s_q.mask),
        .vlen  (s_q.vlen),
        .from  (s_q.elem),
        .incl  (1'b0),
        .found (next_found),
        .idx   (next_idx)
    );

    vlag_decode #(.AW(AW)) u_dec (
        .insn      (s_q.insn),
        .mode      (mode),
        .size_log2 (size_log2),
        .imm       (imm),
        .rd        (rd)
    );

    vlag_addr #(.VLMAX(VLMAX), .AW(AW), .IW(IW)) u_addr (
        .mode      (mode),
        .size_log2 (size_log2),
        .imm       (imm),
        .rs1_vec   (s_q.v1),
        .rs2_vec   (s_q.v2),
        .rs1_vals  (s_q.r1),
        .rs2_vals  (s_q.r2),
        .elem      (s_q.elem),
        .addr      (req_addr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.exc  = 1'b0;
        case (s_q.st)
            vlag_pkg::ST_IDLE: begin
                if (start_valid) begin
                    s_d.insn = insn;
                    s_d.v1   = rs1_vec;
                    s_d.v2   = rs2_vec;
                    s_d.vd   = rd_vec;
                    s_d.mask = pred_mask;
                    s_d.vlen = vl;
                    s_d.r1   = rs1_vals;
                    s_d.r2   = rs2_vals;
                    s_d.elem = first_idx;
                    if (!rd_vec && pred_zero) begin
                        s_d.exc  = 1'b1;
                        s_d.done = 1'b1;
                    end else if (!first_found) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = vlag_pkg::ST_RUN;
                    end
                end
            end
            default: begin
                if (req_ready) begin
                    if (!s_q.vd || !next_found) begin
                        s_d.st   = vlag_pkg::ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.elem = next_idx;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_ready = (s_q.st == vlag_pkg::ST_IDLE);
    assign req_valid   = (s_q.st == vlag_pkg::ST_RUN);
    assign req_elem    = s_q.elem;
    assign req_dest    = s_q.vd ? (rd + 5'(s_q.elem)) : rd;
    assign done        = s_q.done;
    assign exc         = s_q.exc;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_elem))); // R10
    AST_LIVE_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (s_q.mask[req_elem] && (LW'(req_elem) < s_q.vlen))); // R6
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || (req_elem > $past(req_elem)))); // R6
    AST_SCALAR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !s_q.vd) |=> (done && !req_valid)); // R7
    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (done && !req_valid)); // R8
    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !start_ready); // R11
endmodule

// File: tb/vlag_addr_gen_test.sv
module vlag_addr_gen_test;
    localparam int VLMAX = 8;
    localparam int AW    = 32;
    localparam int IW    = $clog2(VLMAX);
    localparam int LW    = $clog2(VLMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic start_ready;
    logic [31:0] insn = '0;
    logic rs1_vec = 1'b0, rs2_vec = 1'b0, rd_vec = 1'b0, pred_zero = 1'b0;
    logic [VLMAX-1:0] pred_mask = '0;
    logic [LW-1:0] vl = '0;
    logic [VLMAX*AW-1:0] rs1_vals = '0, rs2_vals = '0;
    logic req_valid, req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [IW-1:0] req_elem;
    logic [4:0] req_dest;
    logic done, exc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [AW-1:0] r1 [VLMAX];
    logic [AW-1:0] r2 [VLMAX];
    logic [AW-1:0] q_addr [$];
    int q_elem [$];
    int q_dest [$];

    always #5 clk = ~clk;

    vlag_addr_gen #(.VLMAX(VLMAX), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .insn(insn), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec), .rd_vec(rd_vec),
        .pred_zero(pred_zero), .pred_mask(pred_mask), .vl(vl),
        .rs1_vals(rs1_vals), .rs2_vals(rs2_vals), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
        .req_dest(req_dest), .done(done), .exc(exc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input bit b31, input bit b30, input logic [5:0] hi,
                                       input logic [3:0] lo, input logic [2:0] f3,
                                       input logic [4:0] rd);
        return {b31, b30, hi, lo, 5'd1, f3, rd, 7'h07};
    endfunction

    task automatic model(input logic [31:0] w, input bit v1, input bit v2, input bit vd,
                         input logic [7:0] m, input int n);
        longint size;
        longint immv;
        q_addr.delete(); q_elem.delete(); q_dest.delete();
        size = longint'(1) << w[13:12];
        if (w[31])      immv = longint'($signed({w[30], w[23:20]}));
        else if (w[30]) immv = longint'($signed(w[23:20]));
        else            immv = longint'($signed({w[29:24], w[23:20]}));
        for (int i = 0; i < n; i++) begin
            if (m[i]) begin
                longint b, s, off;
                b = longint'(v1 ? r1[i] : r1[0]);
                s = longint'(v2 ? r2[i] : r2[0]);
                if (w[31])      off = s;
                else if (w[30]) off = i * size * s;
                else            off = i * size;
                q_addr.push_back(AW'(b + off + immv));
                q_elem.push_back(i);
                q_dest.push_back(vd ? ((int'(w[11:7]) + i) % 32) : int'(w[11:7]));
                if (!vd) break;
            end
        end
    endtask

    task automatic run(input string tag, input logic [31:0] w, input bit v1, input bit v2,
                       input bit vd, input bit pz, input logic [7:0] m, input int n,
                       input int rmode, input bit poke);
        bit exp_exc;
        bit exp_done;
        exp_exc = !vd && pz;
        if (exp_exc) begin
            q_addr.delete(); q_elem.delete(); q_dest.delete();
        end else model(w, v1, v2, vd, m, n);
        @(negedge clk);
        while (!start_ready) @(negedge clk);
        insn = w; rs1_vec = v1; rs2_vec = v2; rd_vec = vd; pred_zero = pz;
        pred_mask = m; vl = LW'(n);
        for (int i = 0; i < VLMAX; i++) begin
            rs1_vals[i*AW +: AW] = r1[i];
            rs2_vals[i*AW +: AW] = r2[i];
        end
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        if (poke) begin
            start_valid = 1'b1;
            insn = mk(1'b1, 1'b0, 6'd0, 4'd0, 3'd0, 5'd9);
            req_ready = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(start_ready == 1'b0, "R11", "start_ready while busy", start_ready, 0);
                chk(req_valid && int'(req_elem) == q_elem[0], "R11", "held element",
                    req_elem, q_elem[0]);
            end
            start_valid = 1'b0;
        end
        exp_done = (q_addr.size() == 0);
        for (int c = 0; c < 200; c++) begin
            if (c > 0) @(negedge clk);
            if (exp_done) begin
                chk(done == 1'b1, (q_elem.size() == 0 && exp_exc) ? "R8" : "R10", "done pulse",
                    done, 1);
                chk(exc == exp_exc, "R8", "exc", exc, exp_exc);
                chk(req_valid == 1'b0, "R9", "no request at end", req_valid, 0);
                break;
            end
            if (done) chk(1'b0, "R10", {tag, " early done"}, done, 0);
            case (rmode)
                1: req_ready = (c % 2) == 1;
                2: req_ready = (c % 3) == 2;
                default: req_ready = 1'b1;
            endcase
            if (req_valid) begin
                if (q_addr.size() == 0) chk(1'b0, "R6", "unexpected request", req_elem, 0);
                else if (req_ready) begin
                    chk(req_addr == q_addr[0], tag, "address", req_addr, q_addr[0]);
                    chk(int'(req_elem) == q_elem[0], "R6", "element", req_elem, q_elem[0]);
                    chk(int'(req_dest) == q_dest[0], "R7", "dest", req_dest, q_dest[0]);
                    void'(q_addr.pop_front()); void'(q_elem.pop_front());
                    void'(q_dest.pop_front());
                    if (q_addr.size() == 0) exp_done = 1'b1;
                end
            end
            if (c == 199) chk(1'b0, "R10", {tag, " no done"}, 0, 1);
        end
        req_ready = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", done, 0);
    endtask

    initial begin
        for (int i = 0; i < VLMAX; i++) begin
            r1[i] = 32'h1000_0000 + 32'(i) * 32'h100;
            r2[i] = 32'(i * 3 + 2);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0 && exc == 1'b0,
            "R11", "reset state", {start_ready, req_valid, done, exc}, 4'b1000);

        // R1 R4: unit stride, 4-byte elements, positive imm
        run("R1", mk(0, 0, 6'd1, 4'd4, 3'd2, 5'd4), 0, 0, 1, 0, 8'hFF, 8, 0, 0);
        // R1 R5: 8-byte elements, negative imm, sparse mask, vector base
        run("R1", mk(0, 0, 6'h3F, 4'hC, 3'd3, 5'd30), 1, 0, 1, 0, 8'b1010_0110, 8, 1, 0);
        // R2 R4 R6: 2-byte, scalar stride, mask bits above vl
        r2[0] = 32'd3;
        run("R2", mk(0, 1, 6'd0, 4'hF, 3'd1, 5'd2), 0, 0, 1, 0, 8'hFF, 5, 0, 0);
        // R2 R5: 1-byte, vector stride and base
        run("R2", mk(0, 1, 6'd0, 4'd2, 3'd0, 5'd8), 1, 1, 1, 0, 8'b0111_1011, 8, 2, 0);
        // R3: vector index, negative imm
        run("R3", mk(1, 1, 6'd0, 4'd0, 3'd3, 5'd1), 0, 1, 1, 0, 8'hFF, 6, 1, 0);
        // R3 R5: scalar index, vector base
        r2[0] = 32'h40;
        run("R3", mk(1, 0, 6'd0, 4'd7, 3'd2, 5'd5), 1, 0, 1, 0, 8'b1100_0011, 8, 2, 0);
        // R7: scalar destination stops at first live element (3)
        run("R7", mk(0, 0, 6'd0, 4'd0, 3'd2, 5'd17), 1, 0, 0, 0, 8'b0110_1000, 8, 1, 0);
        // R8: zeroing with scalar destination
        run("R8", mk(0, 0, 6'd0, 4'd0, 3'd2, 5'd3), 0, 0, 0, 1, 8'hFF, 8, 0, 0);
        // R8: zeroing ignored for vector destination
        run("R8", mk(0, 0, 6'd0, 4'd1, 3'd1, 5'd3), 0, 0, 1, 1, 8'b0000_0101, 8, 0, 0);
        // R9: zero length, empty mask, mask only above vl
        run("R9", mk(0, 0, 6'd0, 4'd0, 3'd0, 5'd0), 0, 0, 1, 0, 8'hFF, 0, 0, 0);
        run("R9", mk(0, 0, 6'd0, 4'd0, 3'd0, 5'd0), 0, 0, 1, 0, 8'h00, 8, 0, 0);
        run("R9", mk(0, 0, 6'd0, 4'd0, 3'd0, 5'd0), 0, 0, 1, 0, 8'hF0, 4, 0, 0);
        // R11: start offered while busy is ignored
        run("R11", mk(0, 0, 6'd2, 4'd0, 3'd1, 5'd12), 0, 0, 1, 0, 8'b0001_1010, 8, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule